// File: doc/BRIEF.md
# Halfword and Signed-Byte Transfer Address Generator

This block sits beside the load/store unit of a 32-bit core and handles the transfer class that moves halfwords and signed bytes. Each request carries the decoded instruction fields: the indexing mode, the direction of the offset, the writeback request, load versus store, the signed and halfword selects, the immediate flag with its two offset nibbles, and the index of the base register. It also carries the values read for the base and offset registers. One cycle later the block presents the memory address, the value to write back into the base register with its enable, the access size and sign controls, the store data, and one flag for each illegal field combination.

The offset is either an 8-bit immediate built from two nibbles or the value of a register. With pre-indexing the offset is applied before the access. With post-indexing the access uses the unmodified base and the offset only affects the writeback value. The block also turns the raw word returned by memory into the architectural load result. It sign-extends or zero-extends the data according to the registered size and sign controls. The memory bus handshake lives elsewhere.

Top module: `hxfer_agen`

## Requirements
- R1: When `immSel` is 1 the offset is the zero-extended 8-bit value {offHi, offLo}, with offHi as the upper nibble. When `immSel` is 0 the offset is `offRegVal`.
- R2: When `preIndex` is 1, `accAddr` is baseVal + offset if `upDir` is 1 and baseVal - offset if `upDir` is 0, modulo 2^32.
- R3: When `preIndex` is 0, `accAddr` equals the unmodified baseVal. In every case `wbValue` is the base moved by the offset in the direction `upDir` selects.
- R4: `wbEn` is 1 for a request that is post-indexed (`preIndex` 0) or has `wbBit` 1, and 0 otherwise.
- R5: `accLoad` follows `isLoad`, `accSigned` follows `signedSel`, and `accHalf` follows `halfSel`. `halfSel` 0 means a byte access.
- R6: `errWbPost` is 1 exactly when `wbBit` is 1 and `preIndex` is 0.
- R7: `errSignedStore` is 1 exactly when `signedSel` is 1 and `isLoad` is 0.
- R8: `errPcBase` is 1 exactly when `baseIdx` is 15 and `wbBit` is 1. `errPcOffset` is 1 exactly when `immSel` is 0 and `offLo` (the offset register index) is 15. `offLo` equal to 15 in immediate mode raises no flag.
- R9: `extData` is derived from `rdData` using the registered controls. A signed halfword copies bit 15 into bits 31..16. A signed byte copies bit 7 into bits 31..8. An unsigned halfword clears bits 31..16. An unsigned byte clears bits 31..8.
- R10: `wrData` is `storeSrc[15:0]` zero-extended for a halfword access and `storeSrc[7:0]` zero-extended for a byte access.
- R11: The outputs of a request appear with `outValid` 1 exactly one cycle after the edge that samples `reqValid` 1. While `outValid` is 0, including after reset, `wbEn` and all four error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| preIndex | input | 1 | 1: apply offset before access; 0: after |
| upDir | input | 1 | 1: add offset; 0: subtract |
| wbBit | input | 1 | Writeback requested |
| isLoad | input | 1 | 1: load; 0: store |
| signedSel | input | 1 | Signed access |
| halfSel | input | 1 | 1: halfword; 0: byte |
| immSel | input | 1 | 1: immediate offset; 0: register offset |
| offHi | input | 4 | Upper immediate nibble |
| offLo | input | 4 | Lower immediate nibble, or offset register index |
| baseIdx | input | 4 | Base register index |
| baseVal | input | 32 | Base register value |
| offRegVal | input | 32 | Offset register value |
| storeSrc | input | 32 | Source register value for stores |
| rdData | input | 32 | Raw word returned by memory |
| outValid | output | 1 | Results below are valid |
| accAddr | output | 32 | Memory access address |
| wbValue | output | 32 | Value for base register writeback |
| wbEn | output | 1 | Base register writeback enable |
| accLoad | output | 1 | Access is a load |
| accHalf | output | 1 | Access is a halfword |
| accSigned | output | 1 | Access is signed |
| wrData | output | 32 | Store data |
| extData | output | 32 | Extended load result |
| errWbPost | output | 1 | Writeback with post-indexing |
| errSignedStore | output | 1 | Signed select on a store |
| errPcBase | output | 1 | Register 15 as base with writeback |
| errPcOffset | output | 1 | Register 15 as offset register |

## Verification
All results of a request are registered, so they are due at the first rising edge after the edge that samples the request. The exception is `extData`, which follows `rdData` combinationally from those registered controls. The driver changes inputs on the falling edge and queues the expected item. The monitor samples a quarter period after each rising edge, which is after the registers update and before the next drive. At that point it expects exactly one queued item per valid cycle and quiet strobes otherwise. `rdData` is held until the next falling edge, so `extData` is checked against the data that belongs to the request being compared.

// File: rtl/hxfer_pkg.sv
`timescale 1ns/1ps
package hxfer_pkg;
  // strobes from the decode half to the arithmetic half
  typedef struct packed {
    logic usePre;
    logic addUp;
    logic immOff;
    logic wbEn;
    logic isLoad;
    logic isHalf;
    logic isSigned;
    logic errWbPost;
    logic errSignedStore;
    logic errPcBase;
    logic errPcOffset;
  } hxferCtrl_t;
endpackage

// File: rtl/hxfer_ctrl.sv
`timescale 1ns/1ps
module hxfer_ctrl
  import hxfer_pkg::*;
#(
  parameter int REG_IDX_W = 4
) (
  input  logic                 preIndex,
  input  logic                 upDir,
  input  logic                 wbBit,
  input  logic                 isLoad,
  input  logic                 signedSel,
  input  logic                 halfSel,
  input  logic                 immSel,
  input  logic [REG_IDX_W-1:0] offIdx,
  input  logic [REG_IDX_W-1:0] baseIdx,
  output hxferCtrl_t           ctrl
);
  localparam logic [REG_IDX_W-1:0] PC_IDX = {REG_IDX_W{1'b1}};

  always_comb begin
    ctrl.usePre         = preIndex;
    ctrl.addUp          = upDir;
    ctrl.immOff         = immSel;
    ctrl.wbEn           = !preIndex || wbBit;
    ctrl.isLoad         = isLoad;
    ctrl.isHalf         = halfSel;
    ctrl.isSigned       = signedSel;
    ctrl.errWbPost      = wbBit && !preIndex;
    ctrl.errSignedStore = signedSel && !isLoad;
    ctrl.errPcBase      = wbBit && (baseIdx == PC_IDX);
    ctrl.errPcOffset    = !immSel && (offIdx == PC_IDX);
  end
endmodule

// File: rtl/hxfer_dpath.sv
`timescale 1ns/1ps
module hxfer_dpath
  import hxfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  hxferCtrl_t        ctrl,
  input  logic [NIB_W-1:0]  offHi,
  input  logic [NIB_W-1:0]  offLo,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] offRegVal,
  input  logic [DATA_W-1:0] storeSrc,
  input  logic [DATA_W-1:0] rdData,
  output logic              outValid,
  output logic [DATA_W-1:0] accAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbEn,
  output logic              accLoad,
  output logic              accHalf,
  output logic              accSigned,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] extData,
  output logic              errWbPost,
  output logic              errSignedStore,
  output logic              errPcBase,
  output logic              errPcOffset
);
  localparam int IMM_W  = 2 * NIB_W;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] moved;
  logic [DATA_W-1:0] storeNext;

  always_comb begin
    offset    = ctrl.immOff ? {{(DATA_W-IMM_W){1'b0}}, offHi, offLo} : offRegVal;
    moved     = ctrl.addUp ? (baseVal + offset) : (baseVal - offset);
    storeNext = ctrl.isHalf ? {{(DATA_W-HALF_W){1'b0}}, storeSrc[HALF_W-1:0]}
                            : {{(DATA_W-BYTE_W){1'b0}}, storeSrc[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid       <= 1'b0;
      accAddr        <= '0;
      wbValue        <= '0;
      wbEn           <= 1'b0;
      accLoad        <= 1'b0;
      accHalf        <= 1'b0;
      accSigned      <= 1'b0;
      wrData         <= '0;
      errWbPost      <= 1'b0;
      errSignedStore <= 1'b0;
      errPcBase      <= 1'b0;
      errPcOffset    <= 1'b0;
    end else begin
      outValid       <= reqValid;
      wbEn           <= reqValid && ctrl.wbEn;
      errWbPost      <= reqValid && ctrl.errWbPost;
      errSignedStore <= reqValid && ctrl.errSignedStore;
      errPcBase      <= reqValid && ctrl.errPcBase;
      errPcOffset    <= reqValid && ctrl.errPcOffset;
      if (reqValid) begin
        accAddr   <= ctrl.usePre ? moved : baseVal;
        wbValue   <= moved;
        accLoad   <= ctrl.isLoad;
        accHalf   <= ctrl.isHalf;
        accSigned <= ctrl.isSigned;
        wrData    <= storeNext;
      end
    end
  end

  // load result extension driven by the registered size and sign
  always_comb begin
    case ({accSigned, accHalf})
      2'b11:   extData = {{(DATA_W-HALF_W){rdData[HALF_W-1]}}, rdData[HALF_W-1:0]};
      2'b10:   extData = {{(DATA_W-BYTE_W){rdData[BYTE_W-1]}}, rdData[BYTE_W-1:0]};
      2'b01:   extData = {{(DATA_W-HALF_W){1'b0}}, rdData[HALF_W-1:0]};
      default: extData = {{(DATA_W-BYTE_W){1'b0}}, rdData[BYTE_W-1:0]};
    endcase
  end
endmodule

// File: rtl/hxfer_agen.sv
`timescale 1ns/1ps
module hxfer_agen
  import hxfer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NIB_W     = 4,
  parameter int REG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 preIndex,
  input  logic                 upDir,
  input  logic                 wbBit,
  input  logic                 isLoad,
  input  logic                 signedSel,
  input  logic                 halfSel,
  input  logic                 immSel,
  input  logic [NIB_W-1:0]     offHi,
  input  logic [NIB_W-1:0]     offLo,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [DATA_W-1:0]    baseVal,
  input  logic [DATA_W-1:0]    offRegVal,
  input  logic [DATA_W-1:0]    storeSrc,
  input  logic [DATA_W-1:0]    rdData,
  output logic                 outValid,
  output logic [DATA_W-1:0]    accAddr,
  output logic [DATA_W-1:0]    wbValue,
  output logic                 wbEn,
  output logic                 accLoad,
  output logic                 accHalf,
  output logic                 accSigned,
  output logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    extData,
  output logic                 errWbPost,
  output logic                 errSignedStore,
  output logic                 errPcBase,
  output logic                 errPcOffset
);
  hxferCtrl_t ctrl;

  // the low nibble doubles as the offset register index
  logic [REG_IDX_W-1:0] offIdx;
  assign offIdx = REG_IDX_W'(offLo);

  hxfer_ctrl #(.REG_IDX_W(REG_IDX_W)) i_ctrl (
    .preIndex (preIndex),
    .upDir    (upDir),
    .wbBit    (wbBit),
    .isLoad   (isLoad),
    .signedSel(signedSel),
    .halfSel  (halfSel),
    .immSel   (immSel),
    .offIdx   (offIdx),
    .baseIdx  (baseIdx),
    .ctrl     (ctrl)
  );

  hxfer_dpath #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .ctrl          (ctrl),
    .offHi         (offHi),
    .offLo         (offLo),
    .baseVal       (baseVal),
    .offRegVal     (offRegVal),
    .storeSrc      (storeSrc),
    .rdData        (rdData),
    .outValid      (outValid),
    .accAddr       (accAddr),
    .wbValue       (wbValue),
    .wbEn          (wbEn),
    .accLoad       (accLoad),
    .accHalf       (accHalf),
    .accSigned     (accSigned),
    .wrData        (wrData),
    .extData       (extData),
    .errWbPost     (errWbPost),
    .errSignedStore(errSignedStore),
    .errPcBase     (errPcBase),
    .errPcOffset   (errPcOffset)
  );
endmodule

// File: rtl/hxfer_agen_chk.sv
`timescale 1ns/1ps
module hxfer_agen_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              preIndex,
  input logic              wbBit,
  input logic              isLoad,
  input logic              signedSel,
  input logic              halfSel,
  input logic [DATA_W-1:0] baseVal,
  input logic [DATA_W-1:0] rdData,
  input logic              outValid,
  input logic [DATA_W-1:0] accAddr,
  input logic [DATA_W-1:0] wbValue,
  input logic              wbEn,
  input logic              accHalf,
  input logic              accSigned,
  input logic [DATA_W-1:0] extData,
  input logic              errWbPost,
  input logic              errSignedStore,
  input logic              errPcBase,
  input logic              errPcOffset
);
  localparam int HALF_W = 16;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(wbEn || errWbPost || errSignedStore || errPcBase || errPcOffset)); // R11
  AST_WB_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (wbEn == (!$past(preIndex) || $past(wbBit)))); // R4
  AST_PRE_ADDR_IS_WB: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(preIndex)) |-> (accAddr == wbValue)); // R2
  AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(preIndex)) |-> (accAddr == $past(baseVal))); // R3
  AST_ERR_WB_POST: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (errWbPost == ($past(wbBit) && !$past(preIndex)))); // R6
  AST_ERR_SIGNED_STORE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (errSignedStore == ($past(signedSel) && !$past(isLoad)))); // R7
  AST_SIZE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (accHalf == $past(halfSel) && accSigned == $past(signedSel))); // R5
  AST_SEXT_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && accSigned && accHalf) |->
      (extData[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){rdData[HALF_W-1]}})); // R9
endmodule

bind hxfer_agen hxfer_agen_chk #(.DATA_W(DATA_W)) i_hxfer_agen_chk (.*);

// File: tb/test_hxfer_agen.sv
`timescale 1ns/1ps
module test_hxfer_agen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  typedef struct {
    logic        pre;
    logic [31:0] addr;
    logic [31:0] wbv;
    logic        wbe;
    logic        ld, hf, sg;
    logic [31:0] wr;
    logic [31:0] ext;
    logic        eWp, eSs, ePb, ePo;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic preIndex = 1'b0, upDir = 1'b0, wbBit = 1'b0, isLoad = 1'b0;
  logic signedSel = 1'b0, halfSel = 1'b0, immSel = 1'b0;
  logic [3:0]  offHi = '0, offLo = '0, baseIdx = '0;
  logic [31:0] baseVal = '0, offRegVal = '0, storeSrc = '0, rdData = '0;
  logic        outValid, wbEn, accLoad, accHalf, accSigned;
  logic [31:0] accAddr, wbValue, wrData, extData;
  logic        errWbPost, errSignedStore, errPcBase, errPcOffset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hxfer_agen i_hxfer_agen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .preIndex(preIndex),
    .upDir(upDir), .wbBit(wbBit), .isLoad(isLoad), .signedSel(signedSel),
    .halfSel(halfSel), .immSel(immSel), .offHi(offHi), .offLo(offLo),
    .baseIdx(baseIdx), .baseVal(baseVal), .offRegVal(offRegVal),
    .storeSrc(storeSrc), .rdData(rdData), .outValid(outValid),
    .accAddr(accAddr), .wbValue(wbValue), .wbEn(wbEn), .accLoad(accLoad),
    .accHalf(accHalf), .accSigned(accSigned), .wrData(wrData),
    .extData(extData), .errWbPost(errWbPost), .errSignedStore(errSignedStore),
    .errPcBase(errPcBase), .errPcOffset(errPcOffset)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, leaves the request up for one cycle
  task automatic sendReq(input logic pre, input logic up, input logic wb,
                         input logic ld, input logic sg, input logic hf,
                         input logic imm, input logic [3:0] hi, input logic [3:0] lo,
                         input logic [3:0] bIdx, input logic [31:0] base,
                         input logic [31:0] offR, input logic [31:0] src,
                         input logic [31:0] rd);
    expItem_t e;
    logic [31:0] off;
    logic [31:0] mv;
    preIndex = pre; upDir = up; wbBit = wb; isLoad = ld; signedSel = sg;
    halfSel = hf; immSel = imm; offHi = hi; offLo = lo; baseIdx = bIdx;
    baseVal = base; offRegVal = offR; storeSrc = src; rdData = rd;
    reqValid = 1'b1;
    off = imm ? {24'h0, hi, lo} : offR;               // R1
    mv  = up ? base + off : base - off;
    e.pre  = pre;
    e.addr = pre ? mv : base;                         // R2, R3
    e.wbv  = mv;
    e.wbe  = !pre || wb;                              // R4
    e.ld = ld; e.hf = hf; e.sg = sg;                  // R5
    e.wr   = hf ? {16'h0, src[15:0]} : {24'h0, src[7:0]};  // R10
    case ({sg, hf})                                   // R9
      2'b11:   e.ext = {{16{rd[15]}}, rd[15:0]};
      2'b10:   e.ext = {{24{rd[7]}}, rd[7:0]};
      2'b01:   e.ext = {16'h0, rd[15:0]};
      default: e.ext = {24'h0, rd[7:0]};
    endcase
    e.eWp = wb && !pre;                               // R6
    e.eSs = sg && !ld;                                // R7
    e.ePb = wb && (bIdx == 4'hF);                     // R8
    e.ePo = !imm && (lo == 4'hF);                     // R8
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rstN) begin
        if (expQ.size() > 0) begin
          expItem_t e;
          e = expQ.pop_front();
          check("R11 outValid", {31'h0, outValid}, 32'h1);
          check(e.pre ? "R1/R2 accAddr" : "R3 accAddr", accAddr, e.addr);
          check("R3 wbValue", wbValue, e.wbv);
          check("R4 wbEn", {31'h0, wbEn}, {31'h0, e.wbe});
          check("R5 controls", {29'h0, accLoad, accHalf, accSigned}, {29'h0, e.ld, e.hf, e.sg});
          check("R6 errWbPost", {31'h0, errWbPost}, {31'h0, e.eWp});
          check("R7 errSignedStore", {31'h0, errSignedStore}, {31'h0, e.eSs});
          check("R8 pc flags", {30'h0, errPcBase, errPcOffset}, {30'h0, e.ePb, e.ePo});
          check("R9 extData", extData, e.ext);
          check("R10 wrData", wrData, e.wr);
        end else begin
          check("R11 idle", {27'h0, outValid, wbEn, errWbPost, errSignedStore,
                             errPcBase | errPcOffset}, 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outValid", {31'h0, outValid}, 32'h0);
    check("R11 reset wbEn", {31'h0, wbEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // pre, up, immediate, signed halfword load, negative data
    sendReq(1, 1, 0, 1, 1, 1, 1, 4'hA, 4'h5, 4'd2, 32'h0000_1000, 32'h0, 32'h0, 32'h1234_8001);
    // pre, down, register offset, writeback, unsigned halfword load
    sendReq(1, 0, 1, 1, 0, 1, 0, 4'h0, 4'd3, 4'd4, 32'h0000_2000, 32'h0000_0102, 32'h0, 32'hFFFF_ABCD);
    // post, up, immediate, signed byte load, negative byte
    sendReq(0, 1, 0, 1, 1, 0, 1, 4'h1, 4'h0, 4'd1, 32'h0000_3000, 32'h0, 32'h0, 32'h0000_0080);
    // post, down, register, signed byte load, positive byte
    sendReq(0, 0, 0, 1, 1, 0, 0, 4'h0, 4'd7, 4'd5, 32'h0000_4000, 32'h0000_0010, 32'h0, 32'hFFFF_FF7F);
    // unsigned byte load, pre without writeback
    sendReq(1, 1, 0, 1, 0, 0, 1, 4'h0, 4'h4, 4'd6, 32'h0000_5000, 32'h0, 32'h0, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    // halfword store
    sendReq(1, 1, 1, 0, 0, 1, 1, 4'h0, 4'h2, 4'd8, 32'h0000_6000, 32'h0, 32'hCAFE_F00D, 32'h0);
    // byte store, post-indexed
    sendReq(0, 1, 0, 0, 0, 0, 1, 4'h0, 4'h1, 4'd9, 32'h0000_7000, 32'h0, 32'h1234_56A5, 32'h0);
    // R6 writeback with post-indexing
    sendReq(0, 1, 1, 1, 0, 1, 1, 4'h0, 4'h8, 4'd3, 32'h0000_8000, 32'h0, 32'h0, 32'h0);
    // R7 signed store
    sendReq(1, 1, 0, 0, 1, 1, 1, 4'h0, 4'h0, 4'd3, 32'h0000_9000, 32'h0, 32'h0000_1111, 32'h0);
    // R8 base 15 with writeback
    sendReq(1, 1, 1, 1, 0, 1, 1, 4'h0, 4'h2, 4'hF, 32'h0000_0108, 32'h0, 32'h0, 32'h0);
    // R8 base 15 without writeback: no flag
    sendReq(1, 1, 0, 1, 0, 1, 1, 4'h0, 4'h2, 4'hF, 32'h0000_0108, 32'h0, 32'h0, 32'h0);
    // R8 offset register 15
    sendReq(1, 1, 0, 1, 0, 1, 0, 4'h0, 4'hF, 4'd1, 32'h0000_0200, 32'h0000_0004, 32'h0, 32'h0);
    // R8 low nibble 15 in immediate mode: no flag, offset 0xFF (R1)
    sendReq(1, 1, 0, 1, 0, 1, 1, 4'hF, 4'hF, 4'd1, 32'h0000_0200, 32'h0000_0004, 32'h0, 32'h0);
    // R2 wrap below zero
    sendReq(1, 0, 1, 1, 1, 1, 1, 4'h0, 4'h8, 4'd2, 32'h0000_0004, 32'h0, 32'h0, 32'h0000_7FFF);
    // R3 post wrap above top
    sendReq(0, 1, 0, 1, 0, 1, 0, 4'h0, 4'd6, 4'd2, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 32'h0000_FFFF);
    repeat (4) @(negedge clk);
    check("R11 queue drained", expQ.size(), 32'h0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule